// File: doc/BRIEF.md
# Port-Addressed I/O Block Transfer Engine

The engine performs the I/O side of a small 8-bit processor. One start pulse, with a set of command bits, runs either a single port transfer or a repeated block transfer. A single input reads one byte from a port and derives sign, zero and parity flags from it. A single output writes a supplied byte to a port. A block transfer moves a run of bytes between a port and consecutive memory locations, in either direction. A 16-bit memory pointer steps up or down once per byte, and an 8-bit count steps down once per byte.

The port number comes either from an immediate byte or from a port-pointer register value. It always appears on the low half of the 16-bit address bus. The high half carries the accumulator value for an immediate port, or the live byte count for a register port. Memory and I/O cycles share one address and data bus. Each kind has its own request strobe, and one read or write qualifier goes with it.

The sequencer has seven states:
- IDLE waits for start.
- IO_RD is an I/O read cycle.
- MEM_WR writes the byte just read into memory.
- MEM_RD is a memory read cycle.
- IO_WR is an I/O write cycle.
- STEP updates the count and the pointer.
- DONE is the completion cycle.

Its transitions are:
- IDLE→IO_RD on start with an input command.
- IDLE→MEM_RD on start with a block output.
- IDLE→IO_WR on start with a single output.
- IO_RD→MEM_WR in block mode, and IO_RD→DONE otherwise.
- MEM_WR→STEP.
- MEM_RD→IO_WR.
- IO_WR→STEP in block mode, and IO_WR→DONE otherwise.
- STEP→DONE on the last byte. Otherwise STEP goes back to IO_RD (input) or MEM_RD (output).
- DONE→IDLE.

Top module: `iox_engine`

## Requirements
- R1: During every I/O cycle, bus_addr[7:0] carries the port number. The port number is imm_port when cmd_src_reg=0 and cptr_val when cmd_src_reg=1, both latched at start.
- R2: During every I/O cycle, bus_addr[15:8] carries the latched acc_val when cmd_src_reg=0. It carries the current count value (cnt_out, before that byte's decrement) when cmd_src_reg=1.
- R3: After a single input (cmd_dir_in=1, cmd_block=0), the DONE cycle shows the following, with rd_byte holding the byte:
  - flag_s = bit 7 of the byte.
  - flag_z = 1 exactly when the byte is 0x00.
  - flag_p = 1 exactly when the byte has an even number of 1 bits.
- R4: A single output (cmd_dir_in=0, cmd_block=0) drives wr_byte on bus_wdata during its I/O write cycle, and it leaves all three flags unchanged.
- R5: Each I/O cycle asserts io_req for exactly one clock, together with exactly one of bus_rd or bus_wr. io_req and mem_req are never high at the same time.
- R6: A block input does the following for each byte, in this order:
  - an I/O read;
  - a memory write of that byte at the pointer;
  - a step cycle that decrements the count and increments the pointer, or decrements the pointer when cmd_descend=1.
- R7: A block output does a memory read at the pointer, then an I/O write of that byte, then the same step cycle, for each byte.
- R8: A block started with cnt_init=0 transfers 256 bytes.
- R9: When a block completes, cnt_out=0 and flag_z=1. After a block input, flag_s and flag_p reflect the last byte read.
- R10: busy rises in the cycle after start is accepted and stays high until the last transfer cycle. It is high for 1 cycle for a single transfer and for 3·N cycles for an N-byte block. It is followed by exactly one cycle of done with busy low.
- R11: start is ignored while busy is high. The running transfer's count, addresses and data are unaffected.
- R12: After reset the block is idle:
  - busy, done, io_req, mem_req, bus_rd and bus_wr are 0;
  - the flags are 0;
  - cnt_out and mptr_out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cmd_dir_in | input | 1 | 1 = port to CPU/memory, 0 = to port |
| cmd_block | input | 1 | 1 = repeated block transfer |
| cmd_src_reg | input | 1 | 1 = port from cptr_val, 0 = from imm_port |
| cmd_descend | input | 1 | 1 = memory pointer decrements per byte |
| imm_port | input | DATA_W | Immediate port number |
| acc_val | input | DATA_W | Accumulator value for the high address half |
| cptr_val | input | DATA_W | Port-pointer register value |
| cnt_init | input | DATA_W | Initial byte count (0 means 256) |
| mptr_init | input | 2·DATA_W | Initial memory pointer |
| wr_byte | input | DATA_W | Byte for a single output |
| bus_addr | output | 2·DATA_W | Shared address bus |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, sampled at the end of a read cycle |
| mem_req | output | 1 | Memory cycle strobe |
| io_req | output | 1 | I/O cycle strobe |
| bus_rd | output | 1 | Read qualifier |
| bus_wr | output | 1 | Write qualifier |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | DATA_W | Last byte read from a port |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Even-parity flag |
| cnt_out | output | DATA_W | Current byte count |
| mptr_out | output | 2·DATA_W | Current memory pointer |

## Verification
The first bus cycle is due one clock after the edge that samples start. A single transfer's flags, rd_byte and done are due one clock later still. A block takes three clocks per byte, and done is due in the clock after the last step.

The bench drives inputs just after a falling edge. It samples one falling edge plus a small delay after each rising edge, so each bus cycle is observed exactly once. For blocks it counts busy cycles until done and compares them with 3·N. It logs every I/O cycle's address and data with a falling-edge monitor, so the order of the bus traffic is checked against the expected count and pointer values.

// File: rtl/iox_pkg.sv
package iox_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_IO_RD  = 3'd1,
        ST_MEM_WR = 3'd2,
        ST_MEM_RD = 3'd3,
        ST_IO_WR  = 3'd4,
        ST_STEP   = 3'd5,
        ST_DONE   = 3'd6
    } iox_state_e;

endpackage

// File: rtl/iox_seq.sv
module iox_seq
    import iox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmd_dir_in,
    input  logic       cmd_block,
    input  logic       cmd_src_reg,
    input  logic       cmd_descend,
    input  logic       last_byte,
    output iox_state_e state,
    output logic       dir_in_q,
    output logic       block_q,
    output logic       src_reg_q,
    output logic       descend_q,
    output logic       accept,
    output logic       step_en,
    output logic       io_capture,
    output logic       mem_capture,
    output logic       finish_blk,
    output logic       busy,
    output logic       done
);

    iox_state_e state_nx;

    // state register and latched command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dir_in_q  <= 1'b0;
            block_q   <= 1'b0;
            src_reg_q <= 1'b0;
            descend_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                dir_in_q  <= cmd_dir_in;
                block_q   <= cmd_block;
                src_reg_q <= cmd_src_reg;
                descend_q <= cmd_descend;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cmd_dir_in)     state_nx = ST_IO_RD;
                    else if (cmd_block) state_nx = ST_MEM_RD;
                    else                state_nx = ST_IO_WR;
                end
            end
            ST_IO_RD:  state_nx = block_q ? ST_MEM_WR : ST_DONE;
            ST_MEM_WR: state_nx = ST_STEP;
            ST_MEM_RD: state_nx = ST_IO_WR;
            ST_IO_WR:  state_nx = block_q ? ST_STEP : ST_DONE;
            ST_STEP: begin
                if (last_byte)     state_nx = ST_DONE;
                else if (dir_in_q) state_nx = ST_IO_RD;
                else               state_nx = ST_MEM_RD;
            end
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // control outputs
    always_comb begin
        accept      = 1'b0;
        step_en     = 1'b0;
        io_capture  = 1'b0;
        mem_capture = 1'b0;
        busy        = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE:   accept = start;
            ST_IO_RD:  begin busy = 1'b1; io_capture = 1'b1; end
            ST_MEM_WR: busy = 1'b1;
            ST_MEM_RD: begin busy = 1'b1; mem_capture = 1'b1; end
            ST_IO_WR:  busy = 1'b1;
            ST_STEP:   begin busy = 1'b1; step_en = 1'b1; end
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
        finish_blk = step_en && last_byte;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R10
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable({dir_in_q, block_q, src_reg_q, descend_q})); // R11

endmodule

// File: rtl/iox_ptr.sv
module iox_ptr #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              descend,
    input  logic [DATA_W-1:0] cnt_init,
    input  logic [ADDR_W-1:0] mptr_init,
    output logic [DATA_W-1:0] cnt_q,
    output logic [ADDR_W-1:0] mptr_q,
    output logic              last_byte
);

    localparam logic [DATA_W-1:0] CNT_ONE = DATA_W'(1);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mptr_q <= '0;
        end else if (load) begin
            cnt_q  <= cnt_init;
            mptr_q <= mptr_init;
        end else if (step) begin
            cnt_q  <= cnt_q - CNT_ONE;
            mptr_q <= descend ? (mptr_q - PTR_ONE) : (mptr_q + PTR_ONE);
        end
    end

    // a count of zero wraps to the maximum, giving 2**DATA_W transfers
    assign last_byte = (cnt_q == CNT_ONE);

    AST_PTR_MOVES_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (mptr_q != $past(mptr_q))); // R6

endmodule

// File: rtl/iox_flags.sv
module iox_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              finish_blk,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] byte_q,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_p
);

    logic sign_nx, zero_nx, par_nx;

    always_comb begin
        sign_nx = din[DATA_W-1];
        zero_nx = (din == '0);
        par_nx  = ~(^din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            flag_s <= 1'b0;
            flag_z <= 1'b0;
            flag_p <= 1'b0;
        end else if (capture) begin
            byte_q <= din;
            flag_s <= sign_nx;
            flag_z <= zero_nx;
            flag_p <= par_nx;
        end else if (finish_blk) begin
            flag_z <= 1'b1;
        end
    end

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable({flag_s, flag_p, byte_q})); // R4
    AST_Z_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        finish_blk |=> flag_z); // R9

endmodule

// File: rtl/iox_bus.sv
module iox_bus
    import iox_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  iox_state_e        state,
    input  logic              src_reg,
    input  logic [DATA_W-1:0] port_q,
    input  logic [DATA_W-1:0] acc_q,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic [ADDR_W-1:0] mptr_q,
    input  logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              mem_req,
    output logic              io_req,
    output logic              bus_rd,
    output logic              bus_wr
);

    logic [DATA_W-1:0] hi_sel;
    logic [ADDR_W-1:0] io_addr;

    assign hi_sel  = src_reg ? cnt_q : acc_q;
    assign io_addr = {hi_sel, port_q};

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        mem_req   = 1'b0;
        io_req    = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        unique case (state)
            ST_IO_RD: begin
                io_req   = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = io_addr;
            end
            ST_IO_WR: begin
                io_req    = 1'b1;
                bus_wr    = 1'b1;
                bus_addr  = io_addr;
                bus_wdata = data_q;
            end
            ST_MEM_RD: begin
                mem_req  = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = mptr_q;
            end
            ST_MEM_WR: begin
                mem_req   = 1'b1;
                bus_wr    = 1'b1;
                bus_addr  = mptr_q;
                bus_wdata = data_q;
            end
            default: ;
        endcase
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && mem_req)); // R5
    AST_IO_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> ($countones({bus_rd, bus_wr}) == 1)); // R5
    AST_IO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |=> !io_req); // R5

endmodule

// File: rtl/iox_engine.sv
module iox_engine
    import iox_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_dir_in,
    input  logic              cmd_block,
    input  logic              cmd_src_reg,
    input  logic              cmd_descend,
    input  logic [DATA_W-1:0] imm_port,
    input  logic [DATA_W-1:0] acc_val,
    input  logic [DATA_W-1:0] cptr_val,
    input  logic [DATA_W-1:0] cnt_init,
    input  logic [ADDR_W-1:0] mptr_init,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              mem_req,
    output logic              io_req,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_byte,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_p,
    output logic [DATA_W-1:0] cnt_out,
    output logic [ADDR_W-1:0] mptr_out
);

    iox_state_e        state;
    logic              dir_in_q, block_q, src_reg_q, descend_q;
    logic              accept, step_en, io_capture, mem_capture, finish_blk;
    logic              last_byte;
    logic [DATA_W-1:0] port_q, acc_q, data_q;

    iox_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmd_dir_in  (cmd_dir_in),
        .cmd_block   (cmd_block),
        .cmd_src_reg (cmd_src_reg),
        .cmd_descend (cmd_descend),
        .last_byte   (last_byte),
        .state       (state),
        .dir_in_q    (dir_in_q),
        .block_q     (block_q),
        .src_reg_q   (src_reg_q),
        .descend_q   (descend_q),
        .accept      (accept),
        .step_en     (step_en),
        .io_capture  (io_capture),
        .mem_capture (mem_capture),
        .finish_blk  (finish_blk),
        .busy        (busy),
        .done        (done)
    );

    iox_ptr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (step_en),
        .descend   (descend_q),
        .cnt_init  (cnt_init),
        .mptr_init (mptr_init),
        .cnt_q     (cnt_out),
        .mptr_q    (mptr_out),
        .last_byte (last_byte)
    );

    // operand latches: port number, high-address source, transfer byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            acc_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            port_q <= cmd_src_reg ? cptr_val : imm_port;
            acc_q  <= acc_val;
            data_q <= wr_byte;
        end else if (io_capture || mem_capture) begin
            data_q <= bus_rdata;
        end
    end

    iox_flags #(.DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (io_capture),
        .finish_blk (finish_blk),
        .din        (bus_rdata),
        .byte_q     (rd_byte),
        .flag_s     (flag_s),
        .flag_z     (flag_z),
        .flag_p     (flag_p)
    );

    iox_bus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .src_reg   (src_reg_q),
        .port_q    (port_q),
        .acc_q     (acc_q),
        .cnt_q     (cnt_out),
        .mptr_q    (mptr_out),
        .data_q    (data_q),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mem_req   (mem_req),
        .io_req    (io_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr)
    );

    AST_BLOCK_END_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && block_q) |-> (cnt_out == '0)); // R9
    AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(port_q)); // R11

endmodule

// File: tb/sim_iox_engine.sv
module sim_iox_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, cmd_dir_in, cmd_block, cmd_src_reg, cmd_descend;
    logic [7:0]  imm_port, acc_val, cptr_val, cnt_init, wr_byte;
    logic [15:0] mptr_init;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        mem_req, io_req, bus_rd, bus_wr, busy, done;
    logic [7:0]  rd_byte, cnt_out;
    logic        flag_s, flag_z, flag_p;
    logic [15:0] mptr_out;

    always #5 clk = ~clk;

    iox_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_dir_in(cmd_dir_in), .cmd_block(cmd_block),
        .cmd_src_reg(cmd_src_reg), .cmd_descend(cmd_descend),
        .imm_port(imm_port), .acc_val(acc_val), .cptr_val(cptr_val),
        .cnt_init(cnt_init), .mptr_init(mptr_init), .wr_byte(wr_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_req(mem_req), .io_req(io_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .busy(busy), .done(done), .rd_byte(rd_byte),
        .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p),
        .cnt_out(cnt_out), .mptr_out(mptr_out)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bus environment: memory, port data source, I/O cycle log
    logic [7:0]  mem [256];
    logic [7:0]  io_val;
    logic        io_pattern;
    int          io_rd_n, io_n, strobe_bad;
    logic [15:0] io_addr_log [300];
    logic [7:0]  io_data_log [300];

    function automatic logic [7:0] pat(int k);
        return 8'(k * 37 + 11);
    endfunction

    function automatic bit even_ones(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return (n % 2) == 0;
    endfunction

    assign bus_rdata = mem_req ? mem[bus_addr[7:0]] : (io_pattern ? pat(io_rd_n) : io_val);

    always @(negedge clk) begin
        if (io_req && mem_req) strobe_bad++;
        if (io_req && (bus_rd == bus_wr)) strobe_bad++;
        if (io_req) begin
            if (io_n < 300) begin
                io_addr_log[io_n] = bus_addr;
                io_data_log[io_n] = bus_wdata;
            end
            io_n++;
            if (bus_rd) io_rd_n++;
        end
        if (mem_req && bus_wr) mem[bus_addr[7:0]] = bus_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_cmd(input bit din, input bit blk, input bit src, input bit desc,
                           input logic [7:0] imm, input logic [7:0] acc,
                           input logic [7:0] c, input logic [7:0] b,
                           input logic [15:0] hl, input logic [7:0] wb);
        cmd_dir_in = din; cmd_block = blk; cmd_src_reg = src; cmd_descend = desc;
        imm_port = imm; acc_val = acc; cptr_val = c; cnt_init = b;
        mptr_init = hl; wr_byte = wb;
    endtask

    // runs until done; returns busy cycle count, then checks the done pulse
    task automatic run_to_done(output int busy_cyc);
        int guard = 0;
        busy_cyc = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        while (!done && guard < 3000) begin
            if (busy) busy_cyc++;
            tick();
            guard++;
        end
    endtask

    typedef struct packed {
        logic        din;
        logic        src;
        logic [7:0]  imm;
        logic [7:0]  c;
        logic [7:0]  acc;
        logic [7:0]  b;
        logic [7:0]  dat;
        logic [15:0] addr;
        logic [2:0]  szp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 8'h40, 8'h00, 8'h12, 8'h00, 8'h00, 16'h1240, 3'b011},
        '{1'b1, 1'b1, 8'h00, 8'h7E, 8'h00, 8'h05, 8'h80, 16'h057E, 3'b100},
        '{1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 16'h00FF, 3'b101},
        '{1'b0, 1'b1, 8'h00, 8'h01, 8'h00, 8'h9C, 8'h3C, 16'h9C01, 3'b101},
        '{1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 16'h0000, 3'b000},
        '{1'b0, 1'b0, 8'hA0, 8'h00, 8'h5F, 8'h00, 8'hC3, 16'h5FA0, 3'b000},
        '{1'b1, 1'b0, 8'h11, 8'h00, 8'h22, 8'h00, 8'h7F, 16'h2211, 3'b000}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int bc;
        int k;
        logic [7:0] lastb;
        rst_n = 1'b0; start = 1'b0; io_val = 8'h00; io_pattern = 1'b0;
        io_rd_n = 0; io_n = 0; strobe_bad = 0;
        set_cmd(0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h96);
        repeat (3) tick();

        // R12: reset state
        check(!busy && !done && !io_req && !mem_req && !bus_rd && !bus_wr, "R12",
              "strobes/busy/done", {busy, done, io_req, mem_req, bus_rd, bus_wr}, 0);
        check({flag_s, flag_z, flag_p} == 3'b000 && cnt_out == 8'h00 && mptr_out == 16'h0000,
              "R12", "flags/cnt/ptr", {flag_s, flag_z, flag_p, cnt_out}, 0);
        rst_n = 1'b1;
        tick();

        // single transfers from the vector table: R1 R2 R3 R4 R5 R10
        for (int v = 0; v < NVEC; v++) begin
            set_cmd(VEC[v].din, 1'b0, VEC[v].src, 1'b0, VEC[v].imm, VEC[v].acc,
                    VEC[v].c, VEC[v].b, 16'h0000, VEC[v].dat);
            io_val = VEC[v].dat;
            start = 1'b1;
            tick();
            start = 1'b0;
            check(bus_addr == VEC[v].addr, "R1/R2", "single io address",
                  bus_addr, VEC[v].addr);
            check(io_req && !mem_req && busy && (bus_rd == VEC[v].din) && (bus_wr == !VEC[v].din),
                  "R5", "single io strobes", {io_req, mem_req, bus_rd, bus_wr}, {3'b101, !VEC[v].din});
            if (!VEC[v].din)
                check(bus_wdata == VEC[v].dat, "R4", "single write data", bus_wdata, VEC[v].dat);
            tick();
            check(done && !busy && !io_req, "R10", "single done cycle", {done, busy, io_req}, 3'b100);
            check({flag_s, flag_z, flag_p} == VEC[v].szp, "R3/R4", "flags after single",
                  {flag_s, flag_z, flag_p}, VEC[v].szp);
            if (VEC[v].din)
                check(rd_byte == VEC[v].dat, "R3", "rd_byte", rd_byte, VEC[v].dat);
            tick();
            check(!done && !busy, "R10", "done one cycle", done, 0);
        end

        // R6: block input, register port, 3 bytes ascending
        io_pattern = 1'b1; io_rd_n = 0; io_n = 0;
        set_cmd(1, 1, 1, 0, 8'h00, 8'h00, 8'h12, 8'd3, 16'h0040, 8'h00);
        run_to_done(bc);
        check(bc == 9, "R10", "block-in busy cycles", bc, 9);
        check(io_n == 3, "R6", "block-in io cycles", io_n, 3);
        for (int i = 0; i < 3; i++) begin
            check(io_addr_log[i] == {8'(3 - i), 8'h12}, "R2", "block-in io addr",
                  io_addr_log[i], {8'(3 - i), 8'h12});
            check(mem[8'h40 + i] == pat(i + 1), "R6", "block-in mem byte",
                  mem[8'h40 + i], pat(i + 1));
        end
        check(cnt_out == 8'h00 && mptr_out == 16'h0043, "R6", "block-in count/ptr",
              mptr_out, 16'h0043);
        lastb = pat(3);
        check(flag_z && flag_s == lastb[7] && flag_p == even_ones(lastb), "R9",
              "block-in end flags", {flag_s, flag_z, flag_p}, {lastb[7], 1'b1, even_ones(lastb)});
        tick();
        check(!done, "R10", "block done one cycle", done, 0);

        // R7: block output, immediate port, descending from 0x83, 4 bytes
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h96);
        io_n = 0;
        set_cmd(0, 1, 0, 1, 8'h33, 8'hA5, 8'h00, 8'd4, 16'h0083, 8'h00);
        run_to_done(bc);
        check(bc == 12, "R10", "block-out busy cycles", bc, 12);
        check(io_n == 4, "R7", "block-out io cycles", io_n, 4);
        for (int i = 0; i < 4; i++) begin
            check(io_data_log[i] == 8'((8'h83 - i) ^ 8'h96), "R7", "block-out data",
                  io_data_log[i], 8'((8'h83 - i) ^ 8'h96));
            check(io_addr_log[i] == 16'hA533, "R1", "block-out io addr",
                  io_addr_log[i], 16'hA533);
        end
        check(mptr_out == 16'h007F && cnt_out == 8'h00 && flag_z, "R6/R9",
              "descend ptr and end state", mptr_out, 16'h007F);
        tick();

        // R8: count 0 moves 256 bytes
        io_rd_n = 0; io_n = 0;
        set_cmd(1, 1, 1, 0, 8'h00, 8'h00, 8'h44, 8'd0, 16'h0100, 8'h00);
        run_to_done(bc);
        check(bc == 768, "R8", "256-byte busy cycles", bc, 768);
        check(io_n == 256, "R8", "256-byte io cycles", io_n, 256);
        check(io_addr_log[0] == 16'h0044 && io_addr_log[1] == 16'hFF44, "R8",
              "count wrap in address", io_addr_log[1], 16'hFF44);
        check(mptr_out == 16'h0200 && cnt_out == 8'h00, "R8", "256-byte ptr", mptr_out, 16'h0200);
        k = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != pat(i + 1)) k++;
        check(k == 0, "R8", "256-byte memory mismatches", k, 0);
        tick();

        // R11: start while busy is ignored
        io_rd_n = 0; io_n = 0;
        set_cmd(1, 1, 0, 0, 8'h21, 8'h77, 8'h00, 8'd2, 16'h0010, 8'h00);
        start = 1'b1;
        tick();
        set_cmd(0, 0, 1, 1, 8'h99, 8'h00, 8'h55, 8'd9, 16'h0F00, 8'hEE);
        tick();
        tick();
        start = 1'b0;
        k = 0;
        while (!done && k < 100) begin tick(); k++; end
        check(io_n == 2 && io_rd_n == 2, "R11", "io cycles with extra start", io_n, 2);
        check(io_addr_log[0] == 16'h7721 && io_addr_log[1] == 16'h7721, "R11",
              "address unchanged by extra start", io_addr_log[1], 16'h7721);
        check(mptr_out == 16'h0012 && cnt_out == 8'h00, "R11", "ptr unchanged by extra start",
              mptr_out, 16'h0012);
        tick();

        check(strobe_bad == 0, "R5", "strobe rule violations", strobe_bad, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule